// File: doc/BRIEF.md
# DRAM Refresh Timer and CBR Sequencer

This block times DRAM refreshes for a bus controller. A free-running up-counter is compared each cycle against a programmable refresh constant. When the two are equal, a compare-match status flag is raised and the counter restarts from zero. Matches therefore recur with a period of the constant plus one clock.

What a match does depends on a refresh-enable input. With refresh disabled, the flag feeds a maskable interrupt, and software clears the flag by a read-then-write handshake. With refresh enabled, the match launches a CAS-before-RAS refresh cycle, and completing that cycle clears the flag. The refresh cycle places a programmable number of wait states between the CAS assert and the RAS assert. One match that arrives while a refresh is still running is held and served right after it.

Software reaches the block through a single-cycle register port with three addresses: control, counter and constant.

Top module: `dram_refresh_timer`

## Requirements
- R1: After reset the control word reads 0, the counter reads 0, the constant reads all ones, and `cas_o`, `ras_o`, `rfsh_done_o` and `irq_o` are low.
- R2: The counter (address 1) advances by one each clock and loads written data. On the clock after it equals the constant (address 2) it becomes 0.
- R3: On the clock after counter equals constant, the flag (control bit 15) reads 1. A match beats a clear that falls on the same edge.
- R4: With refresh disabled, writing control with bit 15 = 0 after a read (`reg_rd_i`, address 0) that returned bit 15 = 1 clears the flag. Writing bit 15 = 1 leaves it unchanged.
- R5: A flag write of 0 with no read of flag = 1 since the flag was last set leaves the flag at 1.
- R6: While `rfsh_en_i` is 1, the interrupt enable (control bit 14) reads 0, writes to it are ignored, and its stored value is cleared.
- R7: `irq_o` is 1 exactly when the flag is 1, bit 14 reads 1, and refresh is disabled.
- R8: With refresh enabled, a match asserts `cas_o` on the next clock. `cas_o` then stays high alone for 1 + N cycles, where N is control bits 13:12 (00→0, 01→1, 10→2, 11→3 waits). A single cycle follows with `ras_o`, `cas_o` and `rfsh_done_o` all high, and then the strobes drop.
- R9: The flag reads 0 on the clock after `rfsh_done_o`, unless a match falls on that same edge.
- R10: A match during a refresh is held, and the next refresh asserts `cas_o` on the clock right after the done cycle.
- R11: With refresh disabled, no refresh sequence starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rfsh_en_i | input | 1 | Refresh control enable |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe (arms flag clear) |
| reg_sel_i | input | 2 | Register address: 0 control, 1 counter, 2 constant |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_sel_i` (combinational) |
| cas_o | output | 1 | CAS strobe, active high |
| ras_o | output | 1 | RAS strobe, active high |
| rfsh_done_o | output | 1 | Pulse in the last cycle of a refresh |
| irq_o | output | 1 | Compare-match interrupt request |

## Verification
Two events can fall on one clock edge: a counter match that sets the flag, and a software clear of that flag. The bench first arms the clear with a read of the set flag. It then loads the counter with the constant's value, so that the next control write of 0 lands exactly on the match edge.

It then judges three things. The flag must stay at 1. The match must have cancelled the armed read, so a second write of 0 still leaves the flag set. Only a fresh read followed by a write clears it.

// File: rtl/rfsh_pkg.sv
// Shared types and register addresses for the refresh timer.
// Assumes a 2-bit register select and a 2-bit CAS-to-RAS wait field.
package rfsh_pkg;
    localparam int RCW_W = 2;

    localparam logic [1:0] SEL_CTRL = 2'd0;
    localparam logic [1:0] SEL_CNT  = 2'd1;
    localparam logic [1:0] SEL_CST  = 2'd2;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_CAS  = 2'd1,
        ST_WAIT = 2'd2,
        ST_RAS  = 2'd3
    } cbr_state_t;
endpackage

// File: rtl/rfsh_timer.sv
// Refresh counter and constant register with equality compare.
// The counter counts every clock and restarts at zero after a match.
// A software write to the counter overrides counting and restart.
// Assumes at most one of cnt_wr / cst_wr is high in a cycle.
module rfsh_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_wr,
    input  logic             cst_wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] cst_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cst_q;

    // Compare of current counter against constant.
    always_comb hit_o = (cnt_q == cst_q);

    // Counter: write, restart on match, else increment.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (cnt_wr) cnt_q <= wdata;
        else if (hit_o)  cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    // Constant register, resets to all ones so no early match.
    always_ff @(posedge clk) begin
        if (!rst_n)      cst_q <= '1;
        else if (cst_wr) cst_q <= wdata;
    end

    assign cnt_o = cnt_q;
    assign cst_o = cst_q;
endmodule

// File: rtl/rfsh_ctrl_reg.sv
// Control register: compare-match flag with read-arm clear handshake,
// interrupt enable locked to zero in refresh mode, and wait field.
// Assumes hit and done are single-cycle qualified events.
module rfsh_ctrl_reg
    import rfsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic             done,
    input  logic             rfsh_en,
    input  logic             ctl_wr,
    input  logic             ctl_rd,
    input  logic             wd_flag,
    input  logic             wd_ie,
    input  logic [RCW_W-1:0] wd_rcw,
    output logic             flag_o,
    output logic             ie_o,
    output logic [RCW_W-1:0] rcw_o,
    output logic             arm_o
);
    logic             flag_q;
    logic             arm_q;
    logic             ie_q;
    logic [RCW_W-1:0] rcw_q;
    logic             sw_clr;

    // Software clear is legal only when armed and refresh is off.
    always_comb sw_clr = ctl_wr && !wd_flag && arm_q && !rfsh_en;

    // Flag and arm: set wins, then hardware clear, then software clear, then arm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (hit) begin
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
        end else if (done || sw_clr) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (ctl_rd && flag_q) begin
            arm_q  <= 1'b1;
        end
    end

    // Interrupt enable, forced to zero while refresh is active.
    always_ff @(posedge clk) begin
        if (!rst_n)      ie_q <= 1'b0;
        else if (rfsh_en) ie_q <= 1'b0;
        else if (ctl_wr)  ie_q <= wd_ie;
    end

    // CAS-to-RAS wait field.
    always_ff @(posedge clk) begin
        if (!rst_n)     rcw_q <= '0;
        else if (ctl_wr) rcw_q <= wd_rcw;
    end

    assign flag_o = flag_q;
    assign ie_o   = ie_q && !rfsh_en;
    assign rcw_o  = rcw_q;
    assign arm_o  = arm_q;
endmodule

// File: rtl/rfsh_cbr_seq.sv
// CAS-before-RAS refresh sequencer. One CAS cycle, rcw wait cycles,
// one RAS cycle (with done), then idle or straight into a held request.
// Assumes req is a one-cycle pulse; holds at most one extra request.
module rfsh_cbr_seq
    import rfsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic [RCW_W-1:0] rcw,
    output logic             cas_o,
    output logic             ras_o,
    output logic             done_o
);
    cbr_state_t       st_q, st_d;
    logic [RCW_W-1:0] wcnt_q, wcnt_d;
    logic             pend_q, pend_d;

    // Next-state and wait counter logic.
    always_comb begin
        st_d   = st_q;
        wcnt_d = wcnt_q;
        pend_d = pend_q;
        case (st_q)
            ST_IDLE: begin
                if (req) begin
                    st_d   = ST_CAS;
                    wcnt_d = rcw;
                end
            end
            ST_CAS, ST_WAIT: begin
                if (req) pend_d = 1'b1;
                if (wcnt_q == '0) begin
                    st_d = ST_RAS;
                end else begin
                    st_d   = ST_WAIT;
                    wcnt_d = wcnt_q - 1'b1;
                end
            end
            ST_RAS: begin
                if (pend_q || req) begin
                    st_d   = ST_CAS;
                    wcnt_d = rcw;
                    pend_d = pend_q && req;
                end else begin
                    st_d = ST_IDLE;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            wcnt_q <= '0;
            pend_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            wcnt_q <= wcnt_d;
            pend_q <= pend_d;
        end
    end

    assign cas_o  = (st_q != ST_IDLE);
    assign ras_o  = (st_q == ST_RAS);
    assign done_o = (st_q == ST_RAS);
endmodule

// File: rtl/dram_refresh_timer.sv
// Top: refresh timer, control register and CBR sequencer with a
// three-address register port. Read data is combinational on reg_sel_i.
// Assumes CNT_W <= DATA_W and DATA_W >= RCW_W + 2.
module dram_refresh_timer
    import rfsh_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rfsh_en_i,
    input  logic              reg_wr_i,
    input  logic              reg_rd_i,
    input  logic [1:0]        reg_sel_i,
    input  logic [DATA_W-1:0] reg_wdata_i,
    output logic [DATA_W-1:0] reg_rdata_o,
    output logic              cas_o,
    output logic              ras_o,
    output logic              rfsh_done_o,
    output logic              irq_o
);
    localparam int FLAG_BIT = DATA_W - 1;
    localparam int IE_BIT   = DATA_W - 2;
    localparam int RCW_HI   = DATA_W - 3;
    localparam int RCW_LO   = DATA_W - 2 - RCW_W;

    logic              cnt_wr, cst_wr, ctl_wr, ctl_rd;
    logic [CNT_W-1:0]  cnt_q, cst_q;
    logic [DATA_W-1:0] cnt_ext, cst_ext, ctl_word;
    logic              cmp_hit, flag_q, arm_q, ie_eff, seq_done;
    logic [RCW_W-1:0]  rcw_q;

    // Register port decode.
    always_comb begin
        cnt_wr = reg_wr_i && (reg_sel_i == SEL_CNT);
        cst_wr = reg_wr_i && (reg_sel_i == SEL_CST);
        ctl_wr = reg_wr_i && (reg_sel_i == SEL_CTRL);
        ctl_rd = reg_rd_i && (reg_sel_i == SEL_CTRL);
    end

    rfsh_timer #(.CNT_W(CNT_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .cnt_wr(cnt_wr),
        .cst_wr(cst_wr),
        .wdata (reg_wdata_i[CNT_W-1:0]),
        .cnt_o (cnt_q),
        .cst_o (cst_q),
        .hit_o (cmp_hit)
    );

    rfsh_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (cmp_hit),
        .done   (seq_done),
        .rfsh_en(rfsh_en_i),
        .ctl_wr (ctl_wr),
        .ctl_rd (ctl_rd),
        .wd_flag(reg_wdata_i[FLAG_BIT]),
        .wd_ie  (reg_wdata_i[IE_BIT]),
        .wd_rcw (reg_wdata_i[RCW_HI:RCW_LO]),
        .flag_o (flag_q),
        .ie_o   (ie_eff),
        .rcw_o  (rcw_q),
        .arm_o  (arm_q)
    );

    rfsh_cbr_seq u_seq (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (cmp_hit && rfsh_en_i),
        .rcw   (rcw_q),
        .cas_o (cas_o),
        .ras_o (ras_o),
        .done_o(seq_done)
    );

    // Zero-extend counter and constant to the data width.
    generate
        if (CNT_W < DATA_W) begin : g_pad
            assign cnt_ext = {{(DATA_W - CNT_W){1'b0}}, cnt_q};
            assign cst_ext = {{(DATA_W - CNT_W){1'b0}}, cst_q};
        end else begin : g_full
            assign cnt_ext = cnt_q;
            assign cst_ext = cst_q;
        end
    endgenerate

    // Assemble control word.
    always_comb begin
        ctl_word                 = '0;
        ctl_word[FLAG_BIT]       = flag_q;
        ctl_word[IE_BIT]         = ie_eff;
        ctl_word[RCW_HI:RCW_LO]  = rcw_q;
    end

    // Read mux.
    always_comb begin
        case (reg_sel_i)
            SEL_CTRL: reg_rdata_o = ctl_word;
            SEL_CNT:  reg_rdata_o = cnt_ext;
            SEL_CST:  reg_rdata_o = cst_ext;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign rfsh_done_o = seq_done;
    assign irq_o       = flag_q && ie_eff;
endmodule

// File: rtl/rfsh_chk.sv
// Property checker for dram_refresh_timer, attached by bind.
module rfsh_chk (
    input logic clk,
    input logic rst_n,
    input logic hit,
    input logic cnt_zero,
    input logic cnt_wr,
    input logic flag,
    input logic arm,
    input logic done,
    input logic cas,
    input logic ras,
    input logic irq,
    input logic rfsh_en,
    input logic ctl_sel,
    input logic ie_rd
);
    // R2: counter restarts after a match unless overwritten
    p_cnt_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !cnt_wr) |=> cnt_zero);
    // R3: match sets the flag
    p_flag_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> flag);
    // R5: without arm or done the flag cannot drop
    p_flag_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !done && !arm) |=> flag);
    // R6: enable bit reads 0 in refresh mode
    p_ie_locked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rfsh_en && ctl_sel) |-> !ie_rd);
    // R7: no interrupt in refresh mode
    p_irq_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rfsh_en |-> !irq);
    // R8: RAS only inside CAS, one cycle long
    p_ras_in_cas_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ras |-> cas);
    p_ras_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ras |=> !ras);
    // R9: completion clears the flag
    p_done_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !hit) |=> !flag);
    // R11: no refresh starts while disabled
    p_no_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rfsh_en && !cas) |=> !cas);
endmodule

bind dram_refresh_timer rfsh_chk u_rfsh_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .hit     (cmp_hit),
    .cnt_zero(cnt_q == '0),
    .cnt_wr  (cnt_wr),
    .flag    (flag_q),
    .arm     (arm_q),
    .done    (rfsh_done_o),
    .cas     (cas_o),
    .ras     (ras_o),
    .irq     (irq_o),
    .rfsh_en (rfsh_en_i),
    .ctl_sel (reg_sel_i == 2'd0),
    .ie_rd   (reg_rdata_o[IE_BIT])
);

// File: tb/test_dram_refresh_timer.sv
module test_dram_refresh_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rfsh_en = 1'b0;
    logic        reg_wr = 1'b0;
    logic        reg_rd = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic [15:0] reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        cas, ras, done, irq;

    int n_tests = 0;
    int n_fail  = 0;
    int seq_cnt = 0;
    int exp_q[$];

    always #10 clk = ~clk;

    dram_refresh_timer i_dram_refresh_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .rfsh_en_i  (rfsh_en),
        .reg_wr_i   (reg_wr),
        .reg_rd_i   (reg_rd),
        .reg_sel_i  (reg_sel),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .cas_o      (cas),
        .ras_o      (ras),
        .rfsh_done_o(done),
        .irq_o      (irq)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // All tasks start at a falling edge and return at the next one.
    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] s, input logic [15:0] d);
        reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] s, output logic [15:0] d);
        reg_rd = 1'b1; reg_sel = s;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic peek(input logic [1:0] s, output logic [15:0] d);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    // Monitor: measures each refresh and compares against the expected queue.
    int cas_run = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (ras && !cas) check(1'b0, "R8", "ras without cas", 1, 0);
            if (cas && !ras) begin
                cas_run++;
            end else if (cas && ras) begin
                seq_cnt++;
                check(done == 1'b1, "R8", "done in ras cycle", int'(done), 1);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R11", "unexpected refresh", seq_cnt, 0);
                end else begin
                    int w;
                    w = exp_q.pop_front();
                    check(cas_run == w + 1, "R8", "cas-only cycles", cas_run, w + 1);
                end
                cas_run = 0;
            end else begin
                cas_run = 0;
            end
        end
    end

    initial begin
        #(20 * 100000);
        check(1'b0, "WDOG", "watchdog expired", 0, 1);
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        step(3);
        rst_n = 1'b1;
        // R1 reset state
        peek(2'd0, d); check(d == 16'h0000, "R1", "ctrl", d, 16'h0000);
        peek(2'd1, d); check(d == 16'h0000, "R1", "counter", d, 0);
        peek(2'd2, d); check(d == 16'hFFFF, "R1", "constant", d, 16'hFFFF);
        check({cas, ras, done, irq} == 4'b0, "R1", "outputs", {cas, ras, done, irq}, 0);

        // R2 counter write and count
        wr(2'd1, 16'd100);
        peek(2'd1, d); check(d == 16'd100, "R2", "counter load", d, 100);
        step(1);
        peek(2'd1, d); check(d == 16'd101, "R2", "counter inc", d, 101);

        // R3 match sets flag; R2 restart
        wr(2'd2, 16'd10);
        wr(2'd1, 16'd5);
        step(5);
        peek(2'd0, d); check(d[15] == 1'b0, "R3", "flag before match", d[15], 0);
        peek(2'd1, d); check(d == 16'd10, "R2", "counter at match", d, 10);
        step(1);
        peek(2'd0, d); check(d[15] == 1'b1, "R3", "flag after match", d[15], 1);
        peek(2'd1, d); check(d == 16'd0, "R2", "restart", d, 0);
        wr(2'd2, 16'hFFFF);

        // R5 write 0 without read keeps flag; R7 irq
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d == 16'hC000, "R5", "flag kept", d, 16'hC000);
        check(irq == 1'b1, "R7", "irq asserted", irq, 1);
        rd(2'd0, d);
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d == 16'h4000, "R4", "clear after read", d, 16'h4000);
        check(irq == 1'b0, "R7", "irq dropped", irq, 0);

        // R4 write 1 has no effect
        wr(2'd2, 16'd20);
        wr(2'd1, 16'd18);
        step(3);
        wr(2'd2, 16'hFFFF);
        rd(2'd0, d); check(d[15] == 1'b1, "R3", "flag set", d[15], 1);
        wr(2'd0, 16'hC000);
        peek(2'd0, d); check(d[15] == 1'b1, "R4", "write 1 ignored", d[15], 1);
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d[15] == 1'b0, "R4", "armed clear", d[15], 0);

        // R3/R5 collision of match and software clear
        wr(2'd2, 16'd30);
        wr(2'd1, 16'd28);
        step(3);
        wr(2'd1, 16'd500);
        rd(2'd0, d); check(d[15] == 1'b1, "R3", "flag before collision", d[15], 1);
        wr(2'd1, 16'd30);
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d[15] == 1'b1, "R3", "set wins collision", d[15], 1);
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d[15] == 1'b1, "R5", "arm lost on set", d[15], 1);
        rd(2'd0, d);
        wr(2'd0, 16'h4000);
        wr(2'd2, 16'hFFFF);
        peek(2'd0, d); check(d[15] == 1'b0, "R4", "clear after re-read", d[15], 0);
        check(seq_cnt == 0, "R11", "no refresh while disabled", seq_cnt, 0);

        // R6 interrupt enable locked in refresh mode
        rfsh_en = 1'b1;
        peek(2'd0, d); check(d[14] == 1'b0, "R6", "ie reads 0", d[14], 0);
        wr(2'd0, 16'h4000);
        peek(2'd0, d); check(d[14] == 1'b0, "R6", "ie write ignored", d[14], 0);
        rfsh_en = 1'b0;
        peek(2'd0, d); check(d[14] == 1'b0, "R6", "ie cleared", d[14], 0);
        rfsh_en = 1'b1;

        // R8/R9 one refresh per wait setting
        for (int w = 0; w < 4; w++) begin
            wr(2'd0, 16'(w << 12));
            exp_q.push_back(w);
            wr(2'd2, 16'd40);
            wr(2'd1, 16'd38);
            step(3);
            peek(2'd0, d);
            check(cas && !ras, "R8", "cas after match", {cas, ras}, 2'b10);
            check(d[15] == 1'b1, "R3", "flag in refresh", d[15], 1);
            step(w + 3);
            peek(2'd0, d);
            check(!cas, "R8", "strobes released", cas, 0);
            check(d[15] == 1'b0, "R9", "flag cleared by refresh", d[15], 0);
            wr(2'd2, 16'hFFFF);
            wr(2'd1, 16'd1000);
        end

        // R10 held request served right after done
        wr(2'd0, 16'h3000);
        exp_q.push_back(3);
        exp_q.push_back(3);
        wr(2'd2, 16'd40);
        wr(2'd1, 16'd39);
        step(2);
        wr(2'd1, 16'd40);
        step(3);
        check(ras && done, "R10", "first ras", {ras, done}, 2'b11);
        step(1);
        check(cas && !ras, "R10", "back-to-back cas", {cas, ras}, 2'b10);
        step(6);
        check(!cas, "R10", "second refresh ended", cas, 0);
        wr(2'd2, 16'hFFFF);
        wr(2'd1, 16'd1000);
        step(2);
        check(seq_cnt == 6, "R8", "refresh count", seq_cnt, 6);
        check(exp_q.size() == 0, "R10", "expected refreshes left", exp_q.size(), 0);

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule